// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level translation structure held in memory. Software loads a directory base register with the address of the page directory. When a translation request is accepted, the walker reads one directory entry. That entry locates a page table. The walker then reads one page-table entry, which locates the page frame, and joins the frame with the page offset.

The entry reads go out on a 32-bit memory read port. The port has a request/grant handshake and a separate read-data valid strobe, and only one read is outstanding at any time. Each entry contributes only its upper 20 bits as a 4 KiB-aligned base. Bit 0 of each entry is a present flag. A clear present flag in either entry ends the walk with a page fault, and the faulting linear address is reported. The result comes back with a one-cycle completion pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, and mem_req_o and done_o are 0.
- R2: The first read of a walk goes to {base[31:12], lin[31:22], 2'b00}, where base is the directory base register. Bits [11:0] of the directory base are ignored.
- R3: The second read of a walk goes to {dir_entry[31:12], lin[21:12], 2'b00}. Bits [11:1] of the directory entry are ignored.
- R4: On success, done_o pulses with fault_o = 0 and phys_o = {pt_entry[31:12], lin[11:0]}. Bits [11:1] of the page-table entry are ignored.
- R5: If bit 0 of the directory entry is 0, the walk ends with no second read. done_o and fault_o are then 1, and fault_addr_o equals the linear address.
- R6: If bit 0 of the page-table entry is 0, the walk ends after two reads. done_o and fault_o are then 1, and fault_addr_o equals the linear address.
- R7: At most one read is outstanding. mem_req_o and mem_addr_o hold steady until mem_gnt_i, and the second read is issued only after the first read's mem_rvalid_i.
- R8: A request is accepted only when req_ready_o is 1, which is only between walks. req_valid_i is ignored while a walk is in progress.
- R9: A write to the directory base register (base_we_i) is used from the next accepted request. A walk already in progress, or one accepted in the same cycle as the write, uses the earlier value.
- R10: done_o is high for exactly one cycle. req_ready_o is 1 in the cycle after it.
- R11: Linear address 0x08147258 reads directory index 0x020 (byte offset 0x080) and table index 0x147 (byte offset 0x51C), and yields offset 0x258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the directory base register |
| base_i | input | 32 | New directory base value |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, can accept a request |
| req_lin_i | input | 32 | Linear address to translate |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (entry) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Page fault, valid with done_o |
| phys_o | output | 32 | Physical address, valid with done_o when no fault |
| fault_addr_o | output | 32 | Faulting linear address, valid with done_o |

## Verification
The bench sweeps every directory index, and then every table index under one present directory entry. The entries it serves have nonzero junk in bits [11:1] and present bits that follow fixed index patterns. A walker that failed to mask the low entry bits would produce wrong second-read or physical addresses. A walker that ignored the present bit would issue a stray second read or report no fault. Grant and response delays vary from walk to walk, so a walker that changed its address before the grant, or issued its next read early, would show up as an unstable address or a wrong read count. Mid-walk base writes and extra requests catch a walker that used the live base, or that took a second request while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_DIR,
    WS_WT_DIR,
    WS_RD_TBL,
    WS_WT_TBL,
    WS_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int AW          = 32,
  parameter int OFF_W       = 12,
  parameter int PRESENT_BIT = 0
) (
  input  logic [AW-1:0]       entry_i,
  output logic [AW-OFF_W-1:0] frame_o,
  output logic                present_o
);
  // low bits other than the present flag are dropped
  assign frame_o   = entry_i[AW-1:OFF_W];
  assign present_o = entry_i[PRESENT_BIT];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW          = 32,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int OFF_W       = 12,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [AW-OFF_W-1:0] dir_frame_i,
  input  logic [AW-OFF_W-1:0] tbl_frame_i,
  input  logic [AW-1:0]       lin_i,
  input  logic                sel_tbl_i,
  output logic [AW-1:0]       entry_addr_o
);
  localparam int FRAME_W   = AW - OFF_W;
  localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
  localparam int LEVELS    = 2;

  logic [FRAME_W-1:0] lvl_frame [LEVELS];
  logic [AW-1:0]      lvl_idx   [LEVELS];
  logic [AW-1:0]      lvl_addr  [LEVELS];

  assign lvl_frame[0] = dir_frame_i;
  assign lvl_frame[1] = tbl_frame_i;
  assign lvl_idx[0]   = AW'(lin_i[AW-1 -: DIR_W]);
  assign lvl_idx[1]   = AW'(lin_i[OFF_W +: TBL_W]);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_addr[g] = {lvl_frame[g], {OFF_W{1'b0}}} | (lvl_idx[g] << ENT_SHIFT);
  end

  assign entry_addr_o = sel_tbl_i ? lvl_addr[1] : lvl_addr[0];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic        present_i,
  output walk_state_e state_o,
  output logic        req_ready_o,
  output logic        accept_o,
  output logic        mem_req_o,
  output logic        sel_tbl_o,
  output logic        dir_take_o,
  output logic        tbl_take_o,
  output logic        done_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:   if (req_valid_i) state_d = WS_RD_DIR;
      WS_RD_DIR: if (mem_gnt_i) state_d = WS_WT_DIR;
      WS_WT_DIR: if (mem_rvalid_i) state_d = present_i ? WS_RD_TBL : WS_DONE;
      WS_RD_TBL: if (mem_gnt_i) state_d = WS_WT_TBL;
      WS_WT_TBL: if (mem_rvalid_i) state_d = WS_DONE;
      WS_DONE:   state_d = WS_IDLE;
      default:   state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign req_ready_o = (state_q == WS_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign mem_req_o   = (state_q == WS_RD_DIR) || (state_q == WS_RD_TBL);
  assign sel_tbl_o   = (state_q == WS_RD_TBL);
  assign dir_take_o  = (state_q == WS_WT_DIR) && mem_rvalid_i;
  assign tbl_take_o  = (state_q == WS_WT_TBL) && mem_rvalid_i;
  assign done_o      = (state_q == WS_DONE);

  // R7: request held until granted
  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o);
  // R7: no new request in the cycle after a grant
  p_one_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o);
  // R10: single-cycle completion, then ready
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
  // R8: never ready while a read is in flight
  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int OFF_W       = 12,
  parameter int ENTRY_BYTES = 4,
  parameter int PRESENT_BIT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_lin_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] phys_o,
  output logic [AW-1:0] fault_addr_o
);
  localparam int FRAME_W   = AW - OFF_W;
  localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);

  walk_state_e        state;
  logic               accept, sel_tbl, dir_take, tbl_take;
  logic [FRAME_W-1:0] rd_frame;
  logic               rd_present;

  logic [FRAME_W-1:0] base_frame_q;  // software-visible base
  logic [FRAME_W-1:0] walk_base_q;   // snapshot for current walk
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [AW-1:0]      lin_q;
  logic [AW-1:0]      phys_q;
  logic               fault_q;

  ptw_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .present_i   (rd_present),
    .state_o     (state),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .mem_req_o   (mem_req_o),
    .sel_tbl_o   (sel_tbl),
    .dir_take_o  (dir_take),
    .tbl_take_o  (tbl_take),
    .done_o      (done_o)
  );

  ptw_entry_decode #(
    .AW(AW), .OFF_W(OFF_W), .PRESENT_BIT(PRESENT_BIT)
  ) u_dec (
    .entry_i  (mem_rdata_i),
    .frame_o  (rd_frame),
    .present_o(rd_present)
  );

  ptw_addr_gen #(
    .AW(AW), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_agen (
    .dir_frame_i (walk_base_q),
    .tbl_frame_i (tbl_frame_q),
    .lin_i       (lin_q),
    .sel_tbl_i   (sel_tbl),
    .entry_addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_frame_q <= '0;
    else if (base_we_i) base_frame_q <= base_i[AW-1:OFF_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_base_q <= '0;
      lin_q       <= '0;
    end else if (accept) begin
      walk_base_q <= base_frame_q;
      lin_q       <= req_lin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_frame_q <= '0;
      phys_q      <= '0;
      fault_q     <= 1'b0;
    end else if (accept) begin
      fault_q <= 1'b0;
      phys_q  <= '0;
    end else if (dir_take) begin
      if (rd_present) tbl_frame_q <= rd_frame;
      else            fault_q     <= 1'b1;
    end else if (tbl_take) begin
      if (rd_present) begin
        phys_q  <= {rd_frame, lin_q[OFF_W-1:0]};
        fault_q <= 1'b0;
      end else begin
        phys_q  <= '0;
        fault_q <= 1'b1;
      end
    end
  end

  assign fault_o      = done_o && fault_q;
  assign phys_o       = phys_q;
  assign fault_addr_o = lin_q;

  // R2: first read uses registered base and incoming directory index
  p_dir_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> mem_req_o &&
      mem_addr_o == {$past(base_frame_q), $past(req_lin_i[AW-1 -: DIR_W]), {ENT_SHIFT{1'b0}}});
  // R3: second read frame comes from the directory entry
  p_tbl_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_take && mem_rdata_i[PRESENT_BIT] |=>
      mem_req_o && mem_addr_o[AW-1:OFF_W] == $past(mem_rdata_i[AW-1:OFF_W]));
  // R5: absent directory entry faults without a second read
  p_dir_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_take && !mem_rdata_i[PRESENT_BIT] |=> done_o && fault_o && !mem_req_o);
  // R4: successful result
  p_phys_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_take && mem_rdata_i[PRESENT_BIT] |=> done_o && !fault_o &&
      phys_o[AW-1:OFF_W] == $past(mem_rdata_i[AW-1:OFF_W]));
  // R6: absent table entry faults
  p_tbl_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_take && !mem_rdata_i[PRESENT_BIT] |=> done_o && fault_o);
  // R7: address steady while waiting for grant
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> $stable(mem_addr_o));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_v = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault;
  logic [31:0] phys, fault_addr;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_i(base_v),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_lin_i(req_lin),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .phys_o(phys), .fault_addr_o(fault_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int gnt_cfg = 0, lat_cfg = 0;
  int nreads = 0, stable_err = 0;
  logic [31:0] rd_addr [4];
  logic [31:0] cur_base = '0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", rq, act, exp);
    end
  endtask

  // entries: bits [11:1] carry junk, bit 0 is present
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [9:0] d, t; logic [3:0] s; logic [19:0] fr; logic p;
    if (a[31:28] == 4'h1) begin
      s = a[15:12]; d = a[11:2]; p = (d % 7) != 3;
      fr = {4'h2, 2'b00, s, d};
      return {fr, 11'h5A3, p};
    end else if (a[31:28] == 4'h2) begin
      s = a[25:22]; d = a[21:12]; t = a[11:2]; p = (t % 5) != 4;
      fr = {d, t} ^ {s, 16'h0} ^ 20'h5A5A5;
      return {fr, 11'h2D6, p};
    end
    return 32'hDEADBEE0;
  endfunction

  // memory responder
  initial begin
    int gw = 0, rw = 0; bit pend = 0; logic [31:0] ra = '0, hold = '0; bit hv = 0;
    forever begin
      @(negedge clk);
      mem_gnt = 0; mem_rvalid = 0;
      if (pend) begin
        if (rw == 0) begin mem_rvalid = 1; mem_rdata = mem_word(ra); pend = 0; end
        else rw--;
      end else if (mem_req) begin
        if (hv && mem_addr != hold) stable_err++;
        hold = mem_addr; hv = 1;
        if (gw == 0) begin
          mem_gnt = 1; ra = mem_addr; pend = 1; rw = lat_cfg;
          if (nreads < 4) rd_addr[nreads] = mem_addr;
          nreads++; gw = gnt_cfg; hv = 0;
        end else gw--;
      end else gw = gnt_cfg;
    end
  end

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1; base_v = v;
    @(negedge clk); base_we = 0;
    cur_base = v;
  endtask

  task automatic walk(input logic [31:0] lin, input bit disturb, input logic [31:0] nb, input string rq);
    logic [9:0] d, t; logic [3:0] s; logic [31:0] a0, a1, ep; bit df, tf;
    s = cur_base[15:12]; d = lin[31:22]; t = lin[21:12];
    a0 = {cur_base[31:12], d, 2'b00};
    a1 = {4'h2, 2'b00, s, d, t, 2'b00};
    df = (d % 7) == 3; tf = (t % 5) == 4;
    ep = {({d, t} ^ {s, 16'h0} ^ 20'h5A5A5), lin[11:0]};
    nreads = 0;
    @(negedge clk); req_valid = 1; req_lin = lin;
    @(negedge clk); req_valid = 0;
    if (disturb) begin
      req_valid = 1; req_lin = ~lin; base_we = 1; base_v = nb;
      @(negedge clk); base_we = 0;
      @(negedge clk); req_valid = 0;
    end
    while (!done) @(negedge clk);
    chk(nreads >= 1 && rd_addr[0] == a0, {rq, " R2 dir addr"}, rd_addr[0], a0);
    if (df) begin
      chk(fault && nreads == 1, {rq, " R5 dir fault, one read"}, nreads, 1);
      chk(fault_addr == lin, {rq, " R5 fault addr"}, fault_addr, lin);
    end else begin
      chk(nreads == 2 && rd_addr[1] == a1, {rq, " R3 tbl addr"}, rd_addr[1], a1);
      if (tf) begin
        chk(fault, {rq, " R6 tbl fault"}, fault, 1);
        chk(fault_addr == lin, {rq, " R6 fault addr"}, fault_addr, lin);
      end else
        chk(!fault && phys == ep, {rq, " R4 phys"}, phys, ep);
    end
    @(negedge clk);
    chk(!done && req_ready, {rq, " R10 pulse/ready"}, {done, req_ready}, 32'h1);
    if (disturb) cur_base = nb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1 reset state", {req_ready, mem_req, done}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1 after reset", {req_ready, mem_req, done}, 32'h4);

    // R11: example address, low base bits ignored (R2)
    set_base(32'h1000_3ABC);
    walk(32'h0814_7258, 0, 0, "R11 example");
    chk(rd_addr[0][11:0] == 12'h080 && rd_addr[1][11:0] == 12'h51C, "R11 indices",
        {rd_addr[0][11:0], rd_addr[1][15:0]}, 32'h080_051C);
    chk(phys[11:0] == 12'h258, "R11 offset", phys[11:0], 12'h258);

    // sweep all directory indices
    for (int i = 0; i < 1024; i++) begin
      gnt_cfg = i % 3; lat_cfg = (i / 3) % 3;
      walk({i[9:0], 10'((i * 37) % 1024), 12'((i * 13) % 4096)}, 0, 0, "sweep dir");
    end
    // sweep all table indices under present directory entry
    set_base(32'h1000_6000);
    for (int i = 0; i < 1024; i++) begin
      gnt_cfg = (i / 2) % 3; lat_cfg = i % 4;
      walk({10'h020, i[9:0], 12'((i * 91) % 4096)}, 0, 0, "sweep tbl");
    end

    // R8/R9: extra request and base write during walk
    gnt_cfg = 2; lat_cfg = 3;
    walk(32'h0814_7258, 1, 32'h1000_9000, "R9 R8 busy");
    chk(nreads == 2, "R8 busy request ignored", nreads, 2);
    walk(32'h0814_7258, 0, 0, "R9 new base");
    chk(rd_addr[0][31:12] == 20'h10009, "R9 new base used", rd_addr[0], 32'h1000_9080);

    // R9: write in the accept cycle is not seen by that walk
    gnt_cfg = 0; lat_cfg = 0;
    nreads = 0;
    @(negedge clk); req_valid = 1; req_lin = 32'h0800_0000; base_we = 1; base_v = 32'h1000_B000;
    @(negedge clk); req_valid = 0; base_we = 0;
    while (!done) @(negedge clk);
    chk(rd_addr[0] == 32'h1000_9080, "R9 same-cycle write", rd_addr[0], 32'h1000_9080);
    @(negedge clk);
    cur_base = 32'h1000_B000;
    walk(32'h0800_0000, 0, 0, "R9 after same-cycle");

    chk(stable_err == 0, "R7 addr stable before grant", stable_err, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule